// File: doc/BRIEF.md
# Two-Layer Perceptron Inference Sequencer

This block evaluates a small two-layer perceptron for a batch of samples. It uses one multiply-accumulate array and one bank of activation logic for both layers, one layer after the other. It reads the samples into the array's stationary operand store and adds a row of ones so that the bias column of each weight matrix is applied by the same multiply-accumulate as the weights. It then streams the hidden-layer weight columns from the weight memory. Next it passes every accumulator through the activation function and writes the results back into the stationary store, again with a row of ones added. It then streams the output-layer weight columns. Finally it writes the activated outputs to the result memory, one word per sample.

All values are 16-bit signed fixed point with 10 fraction bits (1.0 is 1024). A 64-bit memory word holds four lanes, and lane L sits in bits 16L+15:16L. The activation is a saturating linear sigmoid approximation. Every step of the arithmetic is exactly defined, so a software model can predict every output bit.

A run begins with a one-cycle `start` and ends with a one-cycle `done`. The memories are external and synchronous: read data is returned in the cycle after the address.

Top module: `tlp_infer_seq`

## Requirements
- R1: While reset is held, and after its release until a start, `done`, `x_rd_en`, `w_rd_en` and `y_we` are all 0.
- R2: Sample memory word n holds sample n. Feature 0 is in lane 0 and feature 1 is in lane 1. Lanes 2 and 3 have no effect on any result.
- R3: Hidden-layer column k (k=0,1 for the features, k=2 for the bias) is read from weight word k, with lane r holding neuron r. Output-layer column k (k=0..2 for the hidden neurons, k=3 for the bias) is read from weight word 4+k, with lane j holding output j. Weight word 3, lane 3 of words 0..2 and lanes 2..3 of words 4..7 have no effect and word 3 is never read.
- R4: Each pre-activation is the exact sum of products of a weight column and the operand with its ones row (ones row = 1024). This sum is divided by 1024 with rounding toward minus infinity.
- R5: The activation is a = clamp(512 + floor(z/4), 0, 1024). The activated hidden values, with a row of 1024 added, form the operand of the output layer.
- R6: Result word n holds output 0 in lane 0 and output 1 in lane 1, with lanes 2..3 zero. Each of the four words is written exactly once per run, in ascending address order.
- R7: `done` is high for exactly one cycle, 19 clock edges after the edge that accepts `start`, and follows the last result write.
- R8: `start` is ignored while a run is in progress, including the cycle in which `done` is high: no second run starts and no further memory access follows.
- R9: A pre-activation outside the 16-bit range saturates to 32767 or -32768 before activation; it never wraps.
- R10: Each memory read is answered one cycle later, and an accumulation step uses only weight data that was requested in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run when idle |
| done | output | 1 | One-cycle end-of-run pulse |
| x_rd_en | output | 1 | Sample memory read enable |
| x_rd_addr | output | 2 | Sample memory read address |
| x_rd_data | input | 64 | Sample memory read data, one cycle after the address |
| w_rd_en | output | 1 | Weight memory read enable |
| w_rd_addr | output | 3 | Weight memory read address |
| w_rd_data | input | 64 | Weight memory read data, one cycle after the address |
| y_we | output | 1 | Result memory write enable |
| y_addr | output | 2 | Result memory write address |
| y_wdata | output | 64 | Result memory write data |

## Verification
The bench builds the block with its default parameters: four samples per batch, a 2-3-2 network and 16-bit lanes with 10 fraction bits. With this small configuration, every output lane of every sample can be compared against a bit-exact model on every run. The bench runs several dozen batches with pseudo-random weights and samples, alternating a narrow value range (so that activations fall in the linear region) with the full 16-bit range (so that saturation occurs often). The unused lanes and the unused weight word are filled with noise to show that they have no effect. Directed runs cover a realistic trained network, all-zero parameters and forced saturation in both directions. Some runs also pulse `start` repeatedly while busy and during `done`.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_LAYER1,
    S_FEEDBACK,
    S_LAYER2,
    S_DRAIN,
    S_FINISH
  } tlp_state_e;

endpackage

// File: rtl/tlp_act.sv
module tlp_act #(
  parameter int LANE_W   = 16,
  parameter int FRAC     = 10,
  parameter int ACC_W    = 35,
  parameter int SLOPE_SH = 2
) (
  input  logic [ACC_W-1:0]  acc_i,
  output logic [LANE_W-1:0] act_o
);

  localparam int ONE  = 1 << FRAC;
  localparam int HALF = 1 << (FRAC - 1);

  logic signed [ACC_W-1:0]   scaled;
  logic [ACC_W-LANE_W:0]     hi_bits;
  logic [LANE_W-1:0]         z_sat;
  logic signed [LANE_W:0]    lin;

  always_comb begin
    scaled  = $signed(acc_i) >>> FRAC;
    hi_bits = scaled[ACC_W-1:LANE_W-1];
    if (hi_bits == '0 || hi_bits == '1) begin
      z_sat = scaled[LANE_W-1:0];
    end else if (scaled[ACC_W-1]) begin
      z_sat = {1'b1, {(LANE_W-1){1'b0}}};
    end else begin
      z_sat = {1'b0, {(LANE_W-1){1'b1}}};
    end
    lin = ($signed({z_sat[LANE_W-1], z_sat}) >>> SLOPE_SH) + $signed((LANE_W+1)'(HALF));
    if (lin < 0) begin
      act_o = '0;
    end else if (lin > $signed((LANE_W+1)'(ONE))) begin
      act_o = LANE_W'(ONE);
    end else begin
      act_o = lin[LANE_W-1:0];
    end
  end

endmodule

// File: rtl/tlp_mac_array.sv
module tlp_mac_array #(
  parameter int LANE_W = 16,
  parameter int ROWS   = 3,
  parameter int KMAX   = 4,
  parameter int NCOL   = 4,
  parameter int ACC_W  = 35,
  parameter int KI_W   = 2,
  parameter int CI_W   = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     col_we,
  input  logic [CI_W-1:0]                          col_idx,
  input  logic [KMAX-1:0][LANE_W-1:0]              col_data,
  input  logic                                     mat_we,
  input  logic [KMAX-1:0][NCOL-1:0][LANE_W-1:0]    mat_data,
  input  logic                                     clr,
  input  logic                                     mac_en,
  input  logic [KI_W-1:0]                          mac_k,
  input  logic [ROWS-1:0][LANE_W-1:0]              mov,
  output logic [ROWS-1:0][NCOL-1:0][ACC_W-1:0]     acc_o
);

  localparam int PROD_W = 2 * LANE_W;

  logic [KMAX-1:0][NCOL-1:0][LANE_W-1:0] stat_q;
  logic [ROWS-1:0][NCOL-1:0][ACC_W-1:0]  acc_q;

  // stationary operand store
  for (genvar k = 0; k < KMAX; k++) begin : g_srow
    for (genvar c = 0; c < NCOL; c++) begin : g_scol
      logic             st_en;
      logic [LANE_W-1:0] st_d;
      always_comb begin
        st_en = mat_we || (col_we && (col_idx == CI_W'(c)));
        st_d  = mat_we ? mat_data[k][c] : col_data[k];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat_q[k][c] <= '0;
        end else if (st_en) begin
          stat_q[k][c] <= st_d;
        end
      end
    end
  end

  // output-stationary multiply-accumulate cells
  for (genvar r = 0; r < ROWS; r++) begin : g_mrow
    for (genvar c = 0; c < NCOL; c++) begin : g_mcol
      logic signed [PROD_W-1:0] prod;
      logic [ACC_W-1:0]         acc_d;
      logic                     acc_en;
      always_comb begin
        prod   = $signed(mov[r]) * $signed(stat_q[mac_k][c]);
        acc_en = clr || mac_en;
        if (clr) begin
          acc_d = '0;
        end else begin
          acc_d = acc_q[r][c] + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q[r][c] <= '0;
        end else if (acc_en) begin
          acc_q[r][c] <= acc_d;
        end
      end
    end
  end

  assign acc_o = acc_q;

  a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_o == '0));

  a_r10_k_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en |-> (int'(mac_k) < KMAX));

endmodule

// File: rtl/tlp_ctrl.sv
module tlp_ctrl
  import tlp_pkg::*;
#(
  parameter int NSAMP   = 4,
  parameter int K1      = 3,
  parameter int K2      = 4,
  parameter int W1_BASE = 0,
  parameter int W2_BASE = 4,
  parameter int WADDR_W = 3,
  parameter int XADDR_W = 2,
  parameter int KI_W    = 2,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               done,
  output logic               x_rd_en,
  output logic [XADDR_W-1:0] x_rd_addr,
  output logic               w_rd_en,
  output logic [WADDR_W-1:0] w_rd_addr,
  output logic               col_we,
  output logic [XADDR_W-1:0] col_idx,
  output logic               mat_we,
  output logic               clr,
  output logic               mac_en,
  output logic [KI_W-1:0]    mac_k,
  output logic               y_we,
  output logic [XADDR_W-1:0] y_addr
);

  localparam logic [CNT_W-1:0]   NS_C  = CNT_W'(NSAMP);
  localparam logic [CNT_W-1:0]   NSM_C = CNT_W'(NSAMP - 1);
  localparam logic [CNT_W-1:0]   K1_C  = CNT_W'(K1);
  localparam logic [CNT_W-1:0]   K2_C  = CNT_W'(K2);
  localparam logic [WADDR_W-1:0] B1_C  = WADDR_W'(W1_BASE);
  localparam logic [WADDR_W-1:0] B2_C  = WADDR_W'(W2_BASE);

  tlp_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               cnt_en;
  logic               xv_q, wv_q;
  logic [XADDR_W-1:0] xi_q;
  logic [KI_W-1:0]    wk_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    x_rd_en   = 1'b0;
    w_rd_en   = 1'b0;
    w_rd_addr = '0;
    mat_we    = 1'b0;
    clr       = 1'b0;
    y_we      = 1'b0;
    done      = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_FETCH;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      S_FETCH: begin
        x_rd_en = (cnt_q < NS_C);
        cnt_en  = 1'b1;
        if (cnt_q == NS_C) begin
          state_d = S_LAYER1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_LAYER1: begin
        clr       = (cnt_q == '0);
        w_rd_en   = (cnt_q < K1_C);
        w_rd_addr = B1_C + WADDR_W'(cnt_q);
        cnt_en    = 1'b1;
        if (cnt_q == K1_C) begin
          state_d = S_FEEDBACK;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_FEEDBACK: begin
        mat_we  = 1'b1;
        state_d = S_LAYER2;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      S_LAYER2: begin
        clr       = (cnt_q == '0);
        w_rd_en   = (cnt_q < K2_C);
        w_rd_addr = B2_C + WADDR_W'(cnt_q);
        cnt_en    = 1'b1;
        if (cnt_q == K2_C) begin
          state_d = S_DRAIN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_DRAIN: begin
        y_we   = 1'b1;
        cnt_en = 1'b1;
        if (cnt_q == NSM_C) begin
          state_d = S_FINISH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_FINISH: begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // read-return tracking: data arrives one cycle after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xv_q <= 1'b0;
      wv_q <= 1'b0;
      xi_q <= '0;
      wk_q <= '0;
    end else begin
      xv_q <= x_rd_en;
      wv_q <= w_rd_en;
      xi_q <= XADDR_W'(cnt_q);
      wk_q <= KI_W'(cnt_q);
    end
  end

  assign x_rd_addr = XADDR_W'(cnt_q);
  assign y_addr    = XADDR_W'(cnt_q);
  assign col_we    = xv_q;
  assign col_idx   = xi_q;
  assign mac_en    = wv_q;
  assign mac_k     = wk_q;

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(y_we));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && start) |=> !(state_q == S_FETCH && cnt_q == '0));

  a_r6_write_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (y_we && $past(y_we)) |-> (y_addr == $past(y_addr) + 1'b1));

endmodule

// File: rtl/tlp_infer_seq.sv
module tlp_infer_seq #(
  parameter int LANE_W   = 16,
  parameter int FRAC     = 10,
  parameter int LANES    = 4,
  parameter int N_IN     = 2,
  parameter int N_HID    = 3,
  parameter int N_OUT    = 2,
  parameter int W1_BASE  = 0,
  parameter int W2_BASE  = 4,
  localparam int WORD_W  = LANES * LANE_W,
  localparam int NSAMP   = LANES,
  localparam int K1      = N_IN + 1,
  localparam int K2      = N_HID + 1,
  localparam int XADDR_W = (NSAMP > 1) ? $clog2(NSAMP) : 1,
  localparam int WADDR_W = $clog2(W2_BASE + K2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               done,
  output logic               x_rd_en,
  output logic [XADDR_W-1:0] x_rd_addr,
  input  logic [WORD_W-1:0]  x_rd_data,
  output logic               w_rd_en,
  output logic [WADDR_W-1:0] w_rd_addr,
  input  logic [WORD_W-1:0]  w_rd_data,
  output logic               y_we,
  output logic [XADDR_W-1:0] y_addr,
  output logic [WORD_W-1:0]  y_wdata
);

  localparam int KMAX  = (K1 > K2) ? K1 : K2;
  localparam int ROWS  = (N_HID > N_OUT) ? N_HID : N_OUT;
  localparam int KI_W  = (KMAX > 1) ? $clog2(KMAX) : 1;
  localparam int CMAX  = (NSAMP > KMAX) ? NSAMP : KMAX;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam int ACC_W = 2 * LANE_W + KI_W + 1;
  localparam logic [LANE_W-1:0] ONE_C = LANE_W'(1 << FRAC);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_n_s = rs_q[1];

  logic                                   col_we, mat_we, clr, mac_en;
  logic [XADDR_W-1:0]                     col_idx;
  logic [KI_W-1:0]                        mac_k;
  logic [KMAX-1:0][LANE_W-1:0]            col_data;
  logic [KMAX-1:0][NSAMP-1:0][LANE_W-1:0] mat_data;
  logic [ROWS-1:0][LANE_W-1:0]            mov;
  logic [ROWS-1:0][NSAMP-1:0][ACC_W-1:0]  acc;
  logic [ROWS-1:0][NSAMP-1:0][LANE_W-1:0] act_all;

  tlp_ctrl #(
    .NSAMP(NSAMP), .K1(K1), .K2(K2), .W1_BASE(W1_BASE), .W2_BASE(W2_BASE),
    .WADDR_W(WADDR_W), .XADDR_W(XADDR_W), .KI_W(KI_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start(start), .done(done),
    .x_rd_en(x_rd_en), .x_rd_addr(x_rd_addr),
    .w_rd_en(w_rd_en), .w_rd_addr(w_rd_addr),
    .col_we(col_we), .col_idx(col_idx), .mat_we(mat_we), .clr(clr),
    .mac_en(mac_en), .mac_k(mac_k), .y_we(y_we), .y_addr(y_addr)
  );

  // operand padding: features or hidden values, then a ones row, then zeros
  for (genvar k = 0; k < KMAX; k++) begin : g_pad
    if (k < N_IN) begin : g_feat
      assign col_data[k] = x_rd_data[k*LANE_W +: LANE_W];
    end else if (k == N_IN) begin : g_fone
      assign col_data[k] = ONE_C;
    end else begin : g_fzero
      assign col_data[k] = '0;
    end
    for (genvar c = 0; c < NSAMP; c++) begin : g_hcol
      if (k < N_HID) begin : g_hid
        assign mat_data[k][c] = act_all[k][c];
      end else if (k == N_HID) begin : g_hone
        assign mat_data[k][c] = ONE_C;
      end else begin : g_hzero
        assign mat_data[k][c] = '0;
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_mov
    assign mov[r] = w_rd_data[r*LANE_W +: LANE_W];
  end

  tlp_mac_array #(
    .LANE_W(LANE_W), .ROWS(ROWS), .KMAX(KMAX), .NCOL(NSAMP),
    .ACC_W(ACC_W), .KI_W(KI_W), .CI_W(XADDR_W)
  ) u_mac (
    .clk(clk), .rst_n(rst_n_s),
    .col_we(col_we), .col_idx(col_idx), .col_data(col_data),
    .mat_we(mat_we), .mat_data(mat_data),
    .clr(clr), .mac_en(mac_en), .mac_k(mac_k), .mov(mov),
    .acc_o(acc)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_arow
    for (genvar c = 0; c < NSAMP; c++) begin : g_acol
      tlp_act #(
        .LANE_W(LANE_W), .FRAC(FRAC), .ACC_W(ACC_W), .SLOPE_SH(2)
      ) u_act (
        .acc_i(acc[r][c]),
        .act_o(act_all[r][c])
      );
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_out
    if (j < N_OUT) begin : g_val
      assign y_wdata[j*LANE_W +: LANE_W] = act_all[j][y_addr];
      a_r5_act_range: assert property (@(posedge clk) disable iff (!rst_n_s)
        y_we |-> (y_wdata[j*LANE_W +: LANE_W] <= ONE_C));
    end else begin : g_zero
      assign y_wdata[j*LANE_W +: LANE_W] = '0;
    end
  end

  logic unused_lanes;
  assign unused_lanes = ^{x_rd_data, w_rd_data};

  a_r10_mac_follows_read: assert property (@(posedge clk) disable iff (!rst_n_s)
    mac_en |-> $past(w_rd_en));

  a_r10_col_follows_read: assert property (@(posedge clk) disable iff (!rst_n_s)
    col_we |-> $past(x_rd_en));

  a_r3_word3_unread: assert property (@(posedge clk) disable iff (!rst_n_s)
    w_rd_en |-> (int'(w_rd_addr) < W1_BASE + K1 || int'(w_rd_addr) >= W2_BASE));

endmodule

// File: tb/tlp_infer_seq_test.sv
module tlp_infer_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int LAT_EXP    = 19;

  logic        clk, rst_n, start;
  logic        done, x_rd_en, w_rd_en, y_we;
  logic [1:0]  x_rd_addr, y_addr;
  logic [2:0]  w_rd_addr;
  logic [63:0] x_rd_data, w_rd_data, y_wdata;

  logic [63:0] wmem [8];
  logic [63:0] xmem [4];
  logic [63:0] ymem [4];
  int          wr_cnt [4];
  int          wr_order_bad;
  int          last_wr;
  int          w3_reads;
  int          activity;
  longint      exp_y [4][2];
  logic [31:0] seed;

  int checks;
  int errors;

  tlp_infer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .x_rd_en(x_rd_en), .x_rd_addr(x_rd_addr), .x_rd_data(x_rd_data),
    .w_rd_en(w_rd_en), .w_rd_addr(w_rd_addr), .w_rd_data(w_rd_data),
    .y_we(y_we), .y_addr(y_addr), .y_wdata(y_wdata)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // synchronous memories, one-cycle read latency
  always @(posedge clk) begin
    if (x_rd_en) x_rd_data <= xmem[x_rd_addr];
    if (w_rd_en) begin
      w_rd_data <= wmem[w_rd_addr];
      if (w_rd_addr == 3'd3) w3_reads++;
    end
    if (y_we) begin
      ymem[y_addr] <= y_wdata;
      wr_cnt[y_addr]++;
      if (int'(y_addr) != last_wr + 1) wr_order_bad++;
      last_wr = int'(y_addr);
    end
    if (x_rd_en || w_rd_en || y_we) activity++;
  end

  task automatic chk(input string tag, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [15:0] rval(input bit narrow);
    logic [31:0] r;
    r = rnd();
    if (narrow) return {{4{r[11]}}, r[11:0]};
    return r[15:0];
  endfunction

  function automatic longint lane(input logic [63:0] w, input int l);
    return longint'($signed(w[16*l +: 16]));
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint actf(input longint z);
    longint t;
    t = (z >>> 2) + 512;
    if (t < 0) return 0;
    if (t > 1024) return 1024;
    return t;
  endfunction

  task automatic model();
    longint s1 [3];
    longint s2 [4];
    longint acc;
    for (int n = 0; n < 4; n++) begin
      s1[0] = lane(xmem[n], 0);
      s1[1] = lane(xmem[n], 1);
      s1[2] = 1024;
      for (int r = 0; r < 3; r++) begin
        acc = 0;
        for (int k = 0; k < 3; k++) acc += lane(wmem[k], r) * s1[k];
        s2[r] = actf(sat16(acc >>> 10));
      end
      s2[3] = 1024;
      for (int j = 0; j < 2; j++) begin
        acc = 0;
        for (int k = 0; k < 4; k++) acc += lane(wmem[4+k], j) * s2[k];
        exp_y[n][j] = actf(sat16(acc >>> 10));
      end
    end
  endtask

  function automatic logic [63:0] pack4(input int a, input int b, input int c, input int d);
    return {16'(d), 16'(c), 16'(b), 16'(a)};
  endfunction

  task automatic fill_random(input bit narrow);
    for (int i = 0; i < 8; i++)
      wmem[i] = {rval(narrow), rval(narrow), rval(narrow), rval(narrow)};
    for (int i = 0; i < 4; i++)
      xmem[i] = {rval(1'b0), rval(1'b0), rval(narrow), rval(narrow)};
  endtask

  task automatic do_run(input string tag, input bit inject);
    int lat;
    for (int i = 0; i < 4; i++) begin
      wr_cnt[i] = 0;
      ymem[i]   = '1;
    end
    wr_order_bad = 0;
    last_wr      = -1;
    w3_reads     = 0;
    model();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    while (lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
      start = inject && (lat == 4 || lat == 11 || lat == 18);
    end
    chk("R7", {tag, " latency"}, lat, LAT_EXP);
    start = inject;
    @(negedge clk);
    start = 1'b0;
    chk("R7", {tag, " done single cycle"}, done, 0);
    activity = 0;
    repeat (25) @(negedge clk);
    chk("R8", {tag, " no activity after done"}, activity, 0);
    chk("R3", {tag, " weight word 3 reads"}, w3_reads, 0);
    chk("R6", {tag, " write order errors"}, wr_order_bad, 0);
    for (int n = 0; n < 4; n++) begin
      chk("R6", $sformatf("%s word %0d write count", tag, n), wr_cnt[n], 1);
      chk("R5", $sformatf("%s sample %0d out0", tag, n), lane(ymem[n], 0), exp_y[n][0]);
      chk("R5", $sformatf("%s sample %0d out1", tag, n), lane(ymem[n], 1), exp_y[n][1]);
      chk("R6", $sformatf("%s sample %0d upper lanes", tag, n), longint'(ymem[n][63:32]), 0);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    checks   = 0;
    errors   = 0;
    activity = 0;
    seed     = 32'h1234_5678;
    rst_n    = 1'b0;
    start    = 1'b0;
    for (int i = 0; i < 8; i++) wmem[i] = '0;
    for (int i = 0; i < 4; i++) xmem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", done, 0);
    chk("R1", "enables in reset", {x_rd_en, w_rd_en, y_we}, 0);
    rst_n = 1'b1;
    activity = 0;
    repeat (6) @(negedge clk);
    chk("R1", "done after reset", done, 0);
    chk("R1", "no access after reset", activity, 0);

    // R4 R5: trained-style network in Q5.10
    wmem[0] = pack4(1403, 788, 1075, 0);
    wmem[1] = pack4(1403, 993, 655, 0);
    wmem[2] = pack4(-20357, -922, -911, 0);
    wmem[3] = pack4(-1, -1, -1, -1);
    wmem[4] = pack4(7281, -7270, 0, 0);
    wmem[5] = pack4(-1341, 1669, 0, 0);
    wmem[6] = pack4(82, 2017, 0, 0);
    wmem[7] = pack4(-2652, 205, 0, 0);
    xmem[0] = pack4(8192, 8192, 0, 0);
    xmem[1] = pack4(8192, 5120, 0, 0);
    xmem[2] = pack4(5120, 8192, 0, 0);
    xmem[3] = pack4(5120, 5120, 0, 0);
    do_run("R4 trained", 1'b0);

    // R5: all-zero parameters give 0.5 everywhere
    for (int i = 0; i < 8; i++) wmem[i] = '0;
    do_run("R5 zero", 1'b0);
    for (int n = 0; n < 4; n++) chk("R5", "zero params half", lane(ymem[n], 0), 512);

    // R9: forced saturation in both directions
    for (int i = 0; i < 3; i++) wmem[i] = pack4(32767, -32768, 32767, 0);
    for (int i = 4; i < 8; i++) wmem[i] = pack4(32767, -32768, 0, 0);
    for (int n = 0; n < 4; n++) xmem[n] = pack4(32767, 32767 - n * 1000, 0, 0);
    do_run("R9 saturate", 1'b1);
    for (int n = 0; n < 4; n++) begin
      chk("R9", "positive saturation", lane(ymem[n], 0), 1024);
      chk("R9", "negative saturation", lane(ymem[n], 1), 0);
    end

    // R2 R3 R8 R10: sweeps with noise in unused lanes and words
    for (int run = 0; run < 48; run++) begin
      fill_random(run[0] == 1'b0);
      do_run($sformatf("R2 sweep%0d", run), run[1]);
    end

    summary();
    $finish;
  end

endmodule